// File: doc/BRIEF.md
# Low-Half-Adder Tree Multiplier with Incrementer-Select Final Adder

This block multiplies two unsigned W-bit operands (W = 8 by default) and returns the full 2W-bit product. Every pairing of an operand-A bit with an operand-B bit is formed by one AND gate. Bits of equal weight are collected into columns, so the tallest column sits in the middle and the shortest at the two ends. A chain of combinational compression stages then lowers the column heights. Each stage has a height ceiling of 6, 4, 3 and finally 2 for W = 8. Three bits of one column go into a full adder. One or two leftover bits move on to the next stage untouched. A half adder appears only when one full adder too many would be needed to meet the ceiling.

The last stage leaves two rows. A carry-select adder of the square-root kind sums them. Its groups are 2, 2, 3, 4 and 5 bits wide, counted from the least significant bit. Every group after the first builds its carry-in-zero sum with a ripple adder. It builds its carry-in-one result by incrementing that sum, and does not use a second adder. The carry arriving from the group below picks one of the two. An optional output register, enabled by default, registers the product on the rising clock edge and clears it with an asynchronous active-low reset.

Top module: `lean_tree_mult`

## Requirements
- R1: With the output register on (default), `p` equals the unsigned product of the `a` and `b` values sampled at the previous rising edge of `clk`. This holds for all 65536 operand pairs.
- R2: Driving `rst_n` low forces `p` to zero at once, without waiting for a clock edge. `p` stays zero while `rst_n` is low. The first rising edge after release loads the current product.
- R3: A change on `a` or `b` between two rising edges leaves `p` unchanged until the next rising edge.
- R4: The compression stages leave at most two bits in every column. The two resulting rows add up, modulo 2^(2W), to `a*b`. For an operand pair that has one set bit each, at positions i and j, `p` has exactly bit i+j set.
- R5: The final adder splits the 2W bits into groups of 2, 2, 3, 4 and 5 starting at bit 0, so group boundaries fall at bits 2, 4, 7 and 11. Its result equals the sum of the two rows. Sums that carry across any boundary are exact, for example 127, 128, 2047 and 2048.
- R6: A zero operand gives a zero product. The largest operands, 255 × 255, give 65025, and the final adder never carries out of bit 15.
- R7: While `a` and `b` are held constant, `p` keeps its value on every following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low clear of the output register |
| a | input | W (8) | Unsigned multiplicand |
| b | input | W (8) | Unsigned multiplier |
| p | output | 2W (16) | Unsigned product |

## Verification
The bench aims at columns and carry paths that a bad tree or adder would corrupt. Walking one-hot operand pairs place a single partial-product bit in each column. A wrong bit position or a dropped pass-through bit would then show up as a missing or shifted power of two. Products that land on 127, 128, 2047 and 2048 force carries across the carry-select group boundaries. A swapped select or a faulty incrementer would be off by a group weight there, and 255 × 255 runs a carry through every group at once. A full sweep of all operand pairs, a mid-cycle input change and an asynchronous reset pulse catch wrong arithmetic, an output that follows the inputs without waiting for the edge, and a clear that waits for the clock.

// File: rtl/lean_tree_pkg.sv
`timescale 1ns/1ps
package lean_tree_pkg;

    // Packed column-height table: one 8-bit field per column, up to 128 columns.
    localparam int HV_BITS = 1024;
    localparam int HFLD    = 8;

    // Height of column col in the AND matrix of a w x w product.
    function automatic int init_height(int w, int col);
        if (col > 2 * w - 2) return 0;
        return (col < w) ? col + 1 : 2 * w - 1 - col;
    endfunction

    // Number of compression stages: ceilings 2, 3, 4, 6, 9, ... below w.
    function automatic int tree_depth(int w);
        int d;
        int n;
        d = 2;
        n = 0;
        while (d < w) begin
            n++;
            d = (d * 3) / 2;
        end
        return n;
    endfunction

    // Height ceiling that stage `stage` (0 = first) must meet.
    function automatic int height_goal(int w, int stage);
        int d;
        d = 2;
        for (int i = 0; i < tree_depth(w) - 1 - stage; i++) d = (d * 3) / 2;
        return d;
    endfunction

    // Column heights seen at the input of stage `stage`.
    function automatic logic [HV_BITS-1:0] height_vec(int w, int stage);
        int h [128];
        int cin;
        int ex;
        int nfa;
        int nha;
        int tgt;
        logic [HV_BITS-1:0] v;
        for (int c = 0; c < 128; c++) h[c] = (c < 2 * w) ? init_height(w, c) : 0;
        for (int st = 0; st < stage; st++) begin
            tgt = height_goal(w, st);
            cin = 0;
            for (int c = 0; c < 2 * w; c++) begin
                ex   = h[c] + cin - tgt;
                nfa  = (ex > 0) ? ex / 2 : 0;
                nha  = (ex > 0) ? ex % 2 : 0;
                h[c] = h[c] - 2 * nfa - nha + cin;
                cin  = nfa + nha;
            end
        end
        v = '0;
        for (int c = 0; c < 2 * w; c++) v[c*HFLD +: HFLD] = 8'(h[c]);
        return v;
    endfunction

    // Carry-select group sizes from the LSB: 2, 2, 3, 4, 5, 6, ...
    function automatic int grp_size(int idx);
        return (idx < 2) ? 2 : idx + 1;
    endfunction

    function automatic int grp_start(int idx);
        int s;
        s = 0;
        for (int i = 0; i < idx; i++) s += grp_size(i);
        return s;
    endfunction

    function automatic int grp_count(int pw);
        int s;
        int n;
        s = 0;
        n = 0;
        while (s < pw) begin
            s += grp_size(n);
            n++;
        end
        return n;
    endfunction

    function automatic int grp_width(int pw, int idx);
        int st;
        st = grp_start(idx);
        return (st + grp_size(idx) > pw) ? pw - st : grp_size(idx);
    endfunction

endpackage

// File: rtl/lean_tree_ppgen.sv
`timescale 1ns/1ps
module lean_tree_ppgen #(
    parameter int W = 8
) (
    input  logic [W-1:0]            mcand,
    input  logic [W-1:0]            mplier,
    output logic [2*W-1:0][W-1:0]   cols
);
    localparam int PW  = 2 * W;
    localparam int HIW = $clog2(W);
    localparam int CIW = $clog2(PW);

    // Column i+j collects a[i]&b[j]; rows are packed from slot 0 upward.
    always_comb begin
        cols = '0;
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                cols[CIW'(i + j)][HIW'((i + j < W) ? i : W - 1 - j)] = mcand[i] & mplier[j];
            end
        end
    end
endmodule

// File: rtl/lean_tree_stage.sv
`timescale 1ns/1ps
module lean_tree_stage
    import lean_tree_pkg::*;
#(
    parameter int W     = 8,
    parameter int STAGE = 0
) (
    input  logic [2*W-1:0][W-1:0] col_i,
    output logic [2*W-1:0][W-1:0] col_o
);
    localparam int PW   = 2 * W;
    localparam int MAXH = W;
    localparam int HIW  = $clog2(MAXH);
    localparam int CIW  = $clog2(PW);
    localparam int TGT  = height_goal(W, STAGE);
    localparam logic [HV_BITS-1:0] HV = height_vec(W, STAGE);

    // Per column, from LSB: full adders first, a half adder only when the
    // excess over TGT is odd, then pass-through bits, then carries from below.
    always_comb begin
        int h;
        int cin;
        int ex;
        int nfa;
        int nha;
        int rd;
        int wr;
        int npass;
        logic [MAXH-1:0] cbits;
        logic [MAXH-1:0] nbits;
        logic x0;
        logic x1;
        logic x2;
        col_o = '0;
        cin   = 0;
        cbits = '0;
        nbits = '0;
        h = 0; ex = 0; nfa = 0; nha = 0; rd = 0; wr = 0; npass = 0;
        x0 = 1'b0; x1 = 1'b0; x2 = 1'b0;
        for (int c = 0; c < PW; c++) begin
            h     = int'(HV[c*HFLD +: HFLD]);
            ex    = h + cin - TGT;
            nfa   = (ex > 0) ? ex / 2 : 0;
            nha   = (ex > 0) ? ex % 2 : 0;
            nbits = '0;
            rd    = 0;
            wr    = 0;
            for (int k = 0; k < MAXH; k++) begin
                if (k < nfa) begin
                    x0 = col_i[CIW'(c)][HIW'(rd)];
                    x1 = col_i[CIW'(c)][HIW'(rd + 1)];
                    x2 = col_i[CIW'(c)][HIW'(rd + 2)];
                    col_o[CIW'(c)][HIW'(wr)] = x0 ^ x1 ^ x2;
                    nbits[HIW'(k)] = (x0 & x1) | (x2 & (x0 ^ x1));
                    rd += 3;
                    wr += 1;
                end
            end
            if (nha > 0) begin
                x0 = col_i[CIW'(c)][HIW'(rd)];
                x1 = col_i[CIW'(c)][HIW'(rd + 1)];
                col_o[CIW'(c)][HIW'(wr)] = x0 ^ x1;
                nbits[HIW'(nfa)] = x0 & x1;
                rd += 2;
                wr += 1;
            end
            npass = h - rd;
            for (int k = 0; k < MAXH; k++) begin
                if (k < npass) col_o[CIW'(c)][HIW'(wr + k)] = col_i[CIW'(c)][HIW'(rd + k)];
            end
            wr += npass;
            for (int k = 0; k < MAXH; k++) begin
                if (k < cin) col_o[CIW'(c)][HIW'(wr + k)] = cbits[HIW'(k)];
            end
            cbits = nbits;
            cin   = nfa + nha;
        end
    end
endmodule

// File: rtl/lean_tree_csel.sv
`timescale 1ns/1ps
module lean_tree_csel
    import lean_tree_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    output logic [PW-1:0] s,
    output logic          co
);
    localparam int NG = grp_count(PW);

    logic [NG:0] gc;
    assign gc[0] = 1'b0;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int ST = grp_start(g);
        localparam int GW = grp_width(PW, g);

        logic [GW-1:0] xa;
        logic [GW-1:0] ya;
        logic [GW-1:0] s0;
        logic [GW:0]   rc;

        assign xa    = x[ST +: GW];
        assign ya    = y[ST +: GW];
        assign rc[0] = 1'b0;

        // Carry-in-zero ripple sum for this group.
        for (genvar i = 0; i < GW; i++) begin : g_rip
            assign s0[i]   = xa[i] ^ ya[i] ^ rc[i];
            assign rc[i+1] = (xa[i] & ya[i]) | (rc[i] & (xa[i] ^ ya[i]));
        end

        if (g == 0) begin : g_first
            assign s[ST +: GW] = s0;
            assign gc[1]       = rc[GW];
        end else begin : g_sel
            logic [GW:0] xv;
            logic [GW:0] yv;
            logic [GW:0] run;
            assign xv     = {rc[GW], s0};
            assign run[0] = 1'b1;
            // Excess-one converter: {carry, sum} + 1 without a second adder.
            for (genvar i = 0; i <= GW; i++) begin : g_bec
                assign yv[i] = xv[i] ^ run[i];
                if (i < GW) begin : g_run
                    assign run[i+1] = run[i] & xv[i];
                end
            end
            assign s[ST +: GW] = gc[g] ? yv[GW-1:0] : s0;
            assign gc[g+1]     = gc[g] ? yv[GW]     : rc[GW];
        end
    end

    assign co = gc[NG];
endmodule

// File: rtl/lean_tree_mult.sv
`timescale 1ns/1ps
module lean_tree_mult
    import lean_tree_pkg::*;
#(
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [2*W-1:0]   p
);
    localparam int PW   = 2 * W;
    localparam int MAXH = W;
    localparam int NST  = tree_depth(W);

    logic [PW-1:0][MAXH-1:0] tree [NST+1];
    logic [PW-1:0] row_lo;
    logic [PW-1:0] row_hi;
    logic [PW-1:0] sum_w;
    logic          sum_co;
    logic          tall_bits;
    logic          chk_armed;

    lean_tree_ppgen #(.W(W)) u_pp (
        .mcand  (a),
        .mplier (b),
        .cols   (tree[0])
    );

    for (genvar st = 0; st < NST; st++) begin : g_stage
        lean_tree_stage #(.W(W), .STAGE(st)) u_stage (
            .col_i (tree[st]),
            .col_o (tree[st+1])
        );
    end

    always_comb begin
        tall_bits = 1'b0;
        for (int c = 0; c < PW; c++) begin
            row_lo[c] = tree[NST][c][0];
            row_hi[c] = tree[NST][c][1];
            tall_bits = tall_bits | (|tree[NST][c][MAXH-1:2]);
        end
    end

    lean_tree_csel #(.PW(PW)) u_add (
        .x  (row_lo),
        .y  (row_hi),
        .s  (sum_w),
        .co (sum_co)
    );

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) p <= '0;
            else        p <= sum_w;
        end

        assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            chk_armed |-> p == PW'(PW'($past(a)) * PW'($past(b))));

        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            chk_armed && $stable(a) && $stable(b) |=> $stable(p));
    end else begin : g_comb
        assign p = sum_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    assert_rows_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(row_lo + row_hi) == PW'(PW'(a) * PW'(b)));

    assert_two_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tall_bits);

    assert_adder_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sum_w == PW'(row_lo + row_hi));

    assert_no_carry_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_co);
endmodule

// File: tb/lean_tree_mult_bench.sv
`timescale 1ns/1ps
module lean_tree_mult_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] p;

    int checks   = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    lean_tree_mult u_lean_tree_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a),
        .b     (b),
        .p     (p)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: apply operands at the falling edge, queue the expected product.
    task automatic push(input logic [7:0] x, input logic [7:0] y, input string req);
        @(negedge clk);
        a = x;
        b = y;
        exp_q.push_back(16'(x) * 16'(y));
        tag_q.push_back(req);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) begin
            @(posedge clk);
            #6;
        end
    endtask

    // Monitor: one register stage, so compare 5 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() != 0) check(tag_q.pop_front(), p, exp_q.pop_front());
        end
    end

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a = 8'hA5;
        b = 8'h3C;
        repeat (3) @(posedge clk);
        #5 check("R2", p, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: zero operands and the largest pair
        push(8'd0, 8'd255, "R6");
        push(8'd255, 8'd0, "R6");
        push(8'd255, 8'd255, "R6");

        // R4: one partial-product bit per column
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                push(8'(1 << i), 8'(1 << j), "R4");

        // R5: sums that sit on or cross carry-select group boundaries
        push(8'd3,   8'd1,   "R5");
        push(8'd2,   8'd2,   "R5");
        push(8'd15,  8'd1,   "R5");
        push(8'd4,   8'd4,   "R5");
        push(8'd127, 8'd1,   "R5");
        push(8'd8,   8'd16,  "R5");
        push(8'd23,  8'd89,  "R5");
        push(8'd32,  8'd64,  "R5");
        push(8'd129, 8'd127, "R5");

        // R1: every operand pair
        for (int ai = 0; ai < 256; ai++)
            for (int bi = 0; bi < 256; bi++)
                push(8'(ai), 8'(bi), "R1");
        drain();

        // R3: mid-cycle change does not reach p before the edge
        @(negedge clk);
        a = 8'd7;
        b = 8'd9;
        #5 check("R3", p, 16'd65025);
        @(posedge clk);
        #5 check("R3", p, 16'd63);

        // R7: held operands keep p steady
        for (int n = 0; n < 4; n++) begin
            @(posedge clk);
            #5 check("R7", p, 16'd63);
        end

        // R2: asynchronous clear between edges, then reload after release
        #3 rst_n = 1'b0;
        #1 check("R2", p, 16'd0);
        @(posedge clk);
        #5 check("R2", p, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5 check("R2", p, 16'd63);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule